// File: doc/BRIEF.md
# Reset Sequencer with Watchdog

This block gathers every reason to reset a small controller into one synchronous, active-high internal reset on the bus clock. Four sources feed it: a power-on request and a low-voltage request arrive as digital flags, an external active-low reset pin comes in asynchronously, and an internal watchdog counter raises a timeout when software stops servicing it. The power-on request also serves as the block's own synchronous reset.

After power-up the reset is stretched by a fixed oscillator-settling delay. Low-voltage and watchdog events fire a short one-shot, so even a one-cycle request gives a reset of usable length. The block requests the shared open-drain reset pin to be pulled low for power-on and internal events, so that neighbours reset with it. It records which source raised the most recent reset. It captures a boot-mode input at the edge where reset drops.

The watchdog is a free-running counter. A configuration bit enables it, and a bus write to its address with data bit 0 equal to zero restarts it. It is held at zero while reset is active.

Top module: `rstgen_top`

## Requirements
- R1: While `por_req` is high, `rst_out` and `pin_low` are 1, `reset_cause` is 1 (power-on), and `mode_q` is 0.
- R2: After the last edge that samples `por_req` high, `rst_out` stays high for POR_DLY+1 further clock cycles, with nothing else active. `pin_low` falls in the same cycle.
- R3: The external reset passes through a two-flop synchroniser. When `ext_rst_n` is sampled low on w consecutive edges, `rst_out` is high for exactly w cycles, starting two cycles after the first low sample.
- R4: The reset stays asserted until every active source has ended. An external reset held beyond the power-on delay keeps `rst_out` high until it is released.
- R5: When `lvd_req` is sampled high on w consecutive edges, `rst_out` and `pin_low` are both high for w+PULSE_LEN cycles.
- R6: `pin_low` is requested only for power-on, low-voltage and watchdog resets, never for an external reset alone. `pin_low` high always implies `rst_out` high.
- R7: With `wdog_en` at 1 and no service, `rst_out` stays low for exactly 2^WDOG_BITS cycles after release. It is then high for PULSE_LEN+1 cycles, with `pin_low` high as well.
- R8: A write with `reg_wr` high, `reg_addr` equal to WDOG_ADDR and `reg_wdata` bit 0 at 0 restarts the watchdog. If that write is sampled k cycles after release, the low time becomes k+2^WDOG_BITS. A write with bit 0 at 1, or to another address, has no effect.
- R9: With `wdog_en` at 0, the watchdog never raises a reset.
- R10: `reset_cause` changes only on the cycle `rst_out` rises. Its codes are 1 power-on, 2 low-voltage, 3 watchdog and 4 external. When several sources start together, low-voltage wins over watchdog, and watchdog wins over external.
- R11: `mode_q` takes the value of `mode_in` sampled on the edge where `rst_out` falls, and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_req | input | 1 | Power-on request, active high; also the block's synchronous reset |
| lvd_req | input | 1 | Low-voltage request, active high |
| ext_rst_n | input | 1 | External reset pin level, active low, asynchronous |
| wdog_en | input | 1 | Watchdog enable configuration bit |
| reg_wr | input | 1 | Bus write strobe |
| reg_addr | input | ADDR_W | Bus write address |
| reg_wdata | input | DATA_W | Bus write data |
| mode_in | input | MODE_W | Boot-mode selection input |
| rst_out | output | 1 | Internal synchronous reset, active high |
| pin_low | output | 1 | Request to pull the open-drain reset pin low |
| reset_cause | output | 3 | Source of the most recent reset |
| mode_q | output | MODE_W | Mode captured at reset release |

## Verification
External and low-voltage requests are swept over several pulse widths. This separates the two-cycle synchroniser latency from the one-shot stretch, and shows which sources drive the pin. The watchdog is run unserviced, then serviced at several offsets up to the last safe cycle. It is also sent writes with the wrong data bit and the wrong address, and these tell a real restart from a write that is ignored. An external reset held through a power-on delay checks that release waits for the last source. A low-voltage request that arrives together with a synchronised external reset checks the cause priority.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_POR  = 3'd1,
    CAUSE_LV   = 3'd2,
    CAUSE_WDOG = 3'd3,
    CAUSE_EXT  = 3'd4
  } cause_e;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rstgen_por.sv
module rstgen_por #(
  parameter int DELAY = 4064
) (
  input  logic clk,
  input  logic por,
  output logic busy
);
  localparam int CW = $clog2(DELAY + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (por)            cnt <= CW'(DELAY);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/rstgen_pulse.sv
module rstgen_pulse #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic busy
);
  localparam int CW = $clog2(WIDTH + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (trig)      cnt <= CW'(WIDTH);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = trig | (cnt != '0);
endmodule

// File: rtl/rstgen_wdog.sv
module rstgen_wdog #(
  parameter int              BITS   = 18,
  parameter int              ADDR_W = 8,
  parameter int              DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              hold,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ovf
);
  logic [BITS-1:0] cnt;
  logic            clr;

  // service write: address hit with data bit 0 cleared
  assign clr = wr && (addr == ADDR) && ((wdata & DATA_W'(1)) == '0);

  always_ff @(posedge clk) begin
    if (rst || hold || !en || clr) cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assign ovf = en && !hold && !clr && (cnt == '1);
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top #(
  parameter int                POR_DLY   = 4064,
  parameter int                WDOG_BITS = 18,
  parameter int                PULSE_LEN = 4,
  parameter int                SYNC_LEN  = 2,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter int                MODE_W    = 2,
  parameter logic [ADDR_W-1:0] WDOG_ADDR = 8'hF0
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              lvd_req,
  input  logic              ext_rst_n,
  input  logic              wdog_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [MODE_W-1:0] mode_in,
  output logic              rst_out,
  output logic              pin_low,
  output logic [2:0]        reset_cause,
  output logic [MODE_W-1:0] mode_q
);
  import rstgen_pkg::*;

  logic   ext_act, por_busy, pulse_busy, wdog_ovf;
  logic   rst_q, pin_q, rst_next;
  cause_e cause_q, next_cause;

  rstgen_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(por_req), .d(~ext_rst_n), .q(ext_act)
  );

  rstgen_por #(.DELAY(POR_DLY)) u_por (
    .clk(clk), .por(por_req), .busy(por_busy)
  );

  rstgen_wdog #(
    .BITS(WDOG_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR(WDOG_ADDR)
  ) u_wdog (
    .clk(clk), .rst(por_req), .en(wdog_en), .hold(rst_q),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .ovf(wdog_ovf)
  );

  rstgen_pulse #(.WIDTH(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(por_req), .trig(lvd_req | wdog_ovf), .busy(pulse_busy)
  );

  assign rst_next = por_busy | pulse_busy | ext_act;

  always_comb begin
    if (lvd_req)       next_cause = CAUSE_LV;
    else if (wdog_ovf) next_cause = CAUSE_WDOG;
    else               next_cause = CAUSE_EXT;
  end

  always_ff @(posedge clk) begin
    if (por_req) begin
      rst_q   <= 1'b1;
      pin_q   <= 1'b1;
      cause_q <= CAUSE_POR;
      mode_q  <= '0;
    end else begin
      rst_q <= rst_next;
      pin_q <= por_busy | pulse_busy;
      if (!rst_q && rst_next) cause_q <= next_cause;
      if (rst_q && !rst_next) mode_q  <= mode_in;
    end
  end

  assign rst_out     = rst_q;
  assign pin_low     = pin_q;
  assign reset_cause = cause_q;
endmodule

// File: rtl/rstgen_chk.sv
module rstgen_chk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              por_req,
  input logic              lvd_req,
  input logic              ext_rst_n,
  input logic              rst_out,
  input logic              pin_low,
  input logic [2:0]        reset_cause,
  input logic [MODE_W-1:0] mode_in,
  input logic [MODE_W-1:0] mode_q
);
  p_pin_implies_rst_r6: assert property (@(posedge clk) disable iff (por_req)
    pin_low |-> rst_out);

  p_ext_sync_r3: assert property (@(posedge clk) disable iff (por_req)
    $past(!ext_rst_n, 3) |-> rst_out);

  p_lv_reset_r5: assert property (@(posedge clk) disable iff (por_req)
    lvd_req |=> rst_out);

  p_mode_latch_r11: assert property (@(posedge clk) disable iff (por_req)
    $fell(rst_out) |-> (mode_q == $past(mode_in)));

  p_cause_hold_r10: assert property (@(posedge clk) disable iff (por_req)
    !$rose(rst_out) |-> $stable(reset_cause));

  p_cause_legal_r10: assert property (@(posedge clk) disable iff (por_req)
    reset_cause <= 3'd4);
endmodule

bind rstgen_top rstgen_chk #(.MODE_W(MODE_W)) u_chk (
  .clk(clk), .por_req(por_req), .lvd_req(lvd_req), .ext_rst_n(ext_rst_n),
  .rst_out(rst_out), .pin_low(pin_low), .reset_cause(reset_cause),
  .mode_in(mode_in), .mode_q(mode_q)
);

// File: tb/sim_rstgen_top.sv
module sim_rstgen_top;
  localparam int         PD   = 20;
  localparam int         WB   = 6;
  localparam int         PL   = 4;
  localparam int         WPER = 1 << WB;
  localparam logic [7:0] WA   = 8'h3C;

  logic       clk = 1'b0;
  logic       por_req = 1'b1;
  logic       lvd_req = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       wdog_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [1:0] mode_in = 2'd0;
  logic       rst_out, pin_low;
  logic [2:0] reset_cause;
  logic [1:0] mode_q;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  rstgen_top #(
    .POR_DLY(PD), .WDOG_BITS(WB), .PULSE_LEN(PL), .WDOG_ADDR(WA)
  ) u0 (
    .clk(clk), .por_req(por_req), .lvd_req(lvd_req), .ext_rst_n(ext_rst_n),
    .wdog_en(wdog_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mode_in(mode_in), .rst_out(rst_out),
    .pin_low(pin_low), .reset_cause(reset_cause), .mode_q(mode_q)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (rst_out === 1'b1 && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // counts low cycles from the current (low) negedge until rst_out rises
  task automatic measure_low(input int clr_at, input logic [7:0] a,
                             input logic [7:0] d, output int n);
    int guard = 0;
    while (rst_out === 1'b1 && guard < 10000) begin
      guard++;
      @(negedge clk);
    end
    n = 1;
    forever begin
      if (n == clr_at) begin
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      end
      @(negedge clk);
      reg_wr = 1'b0;
      if (rst_out === 1'b1 || n > 5000) break;
      n++;
    end
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, hi, ph;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rst_out === 1'b1, "R1 rst_out", int'(rst_out), 1);
    check(pin_low === 1'b1, "R1 pin_low", int'(pin_low), 1);
    check(reset_cause === 3'd1, "R1 cause", int'(reset_cause), 1);
    check(mode_q === 2'd0, "R1 mode_q", int'(mode_q), 0);

    // R2 power-on delay, R11 mode capture
    mode_in = 2'd2;
    por_req = 1'b0;
    count_high(n);
    check(n == PD + 1, "R2 por length", n, PD + 1);
    check(pin_low === 1'b0, "R2 pin released", int'(pin_low), 0);
    check(mode_q === 2'd2, "R11 mode at por release", int'(mode_q), 2);

    // R4 external reset held through the power-on delay
    por_req = 1'b1;
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b0;
    por_req = 1'b0;
    repeat (30) @(negedge clk);
    check(rst_out === 1'b1, "R4 held by ext", int'(rst_out), 1);
    check(pin_low === 1'b0, "R6 no pin for ext", int'(pin_low), 0);
    mode_in = 2'd1;
    ext_rst_n = 1'b1;
    count_high(n);
    check(n == 3, "R4 ext release latency", n, 3);
    check(mode_q === 2'd1, "R11 mode at ext release", int'(mode_q), 1);

    // R3 external pulse width sweep, R6 no pin, R10 cause
    for (int w = 1; w <= 5; w++) begin
      mode_in = 2'(w);
      ext_rst_n = 1'b0;
      hi = 0; ph = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (i == w - 1) ext_rst_n = 1'b1;
        if (rst_out === 1'b1) hi++;
        if (pin_low === 1'b1) ph++;
      end
      check(hi == w, "R3 ext width", hi, w);
      check(ph == 0, "R6 ext pin", ph, 0);
      check(reset_cause === 3'd4, "R10 ext cause", int'(reset_cause), 4);
      check(mode_q === 2'(w), "R11 mode sweep", int'(mode_q), w & 3);
    end

    // R5 low-voltage width sweep
    for (int w = 1; w <= 4; w++) begin
      lvd_req = 1'b1;
      hi = 0; ph = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (i == w - 1) lvd_req = 1'b0;
        if (rst_out === 1'b1) hi++;
        if (pin_low === 1'b1) ph++;
      end
      check(hi == w + PL, "R5 lv reset width", hi, w + PL);
      check(ph == w + PL, "R5 lv pin width", ph, w + PL);
      check(reset_cause === 3'd2, "R10 lv cause", int'(reset_cause), 2);
    end

    // R10 priority: low-voltage and synchronised external start together
    ext_rst_n = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 1) lvd_req = 1'b1;
      if (i == 2) lvd_req = 1'b0;
      if (i == 12) ext_rst_n = 1'b1;
    end
    check(reset_cause === 3'd2, "R10 priority lv over ext", int'(reset_cause), 2);

    // R10 cause holds while reset already active
    ext_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(reset_cause === 3'd4, "R10 ext cause", int'(reset_cause), 4);
    lvd_req = 1'b1;
    @(negedge clk);
    lvd_req = 1'b0;
    repeat (2) @(negedge clk);
    check(reset_cause === 3'd4, "R10 cause held", int'(reset_cause), 4);
    ext_rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check(rst_out === 1'b0, "R4 all sources ended", int'(rst_out), 0);

    // R7 watchdog timeout from a known release
    wdog_en = 1'b1;
    ext_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b1;
    while (rst_out !== 1'b1) @(negedge clk);
    count_high(n);
    measure_low(0, WA, 8'h00, n);
    check(n == WPER, "R7 wdog period", n, WPER);
    check(pin_low === 1'b1, "R7 wdog pin", int'(pin_low), 1);
    check(reset_cause === 3'd3, "R10 wdog cause", int'(reset_cause), 3);
    count_high(n);
    check(n == PL + 1, "R7 wdog pulse", n, PL + 1);

    // R8 service at several offsets
    for (int j = 0; j < 4; j++) begin
      int k;
      k = (j == 0) ? 1 : (j == 1) ? 10 : (j == 2) ? 40 : WPER - 1;
      measure_low(k, WA, 8'hFE, n);
      check(n == k + WPER, "R8 serviced low time", n, k + WPER);
      count_high(n);
      check(n == PL + 1, "R7 wdog pulse", n, PL + 1);
    end

    // R8 ignored writes
    measure_low(20, WA, 8'h01, n);
    check(n == WPER, "R8 bit0 set ignored", n, WPER);
    count_high(n);
    measure_low(20, WA ^ 8'h01, 8'h00, n);
    check(n == WPER, "R8 other address ignored", n, WPER);

    // R9 watchdog disabled
    wdog_en = 1'b0;
    count_high(n);
    hi = 0;
    for (int i = 0; i < 4 * WPER; i++) begin
      @(negedge clk);
      if (rst_out === 1'b1) hi++;
    end
    check(hi == 0, "R9 disabled no reset", hi, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule